// File: doc/BRIEF.md
# Control-Word Driven Datapath

This block is a datapath slice steered entirely by a horizontal control word presented on an input port each clock. The word names a destination register, two source registers, the source of the second operand, a function code, the write-back source and a write enable. No decoding happens inside: every field drives its piece of hardware directly.

An eight-entry register file has two combinational read ports and one write port that updates on the rising clock edge. Read port A feeds the function unit and also appears on the address-out bus. The second operand is either read port B or an external constant, and that selected operand appears on the data-out bus. The value written back is either the function-unit result or the external data-in bus. The function unit also produces overflow, carry, negative and zero flags, which are always computed from its own result.

Top module: `ctrl_word_datapath`

## Requirements
- R1: The 17-bit control word is packed from bit 16 down as: destination address [16:14], port A address [13:11], port B address [10:8], operand-B select [7], function code [6:2], write-back select [1], write enable [0].
- R2: While reset is asserted, and after it is released, all eight registers read zero until they are written.
- R3: When the write enable bit is 0, no register changes, whatever the other fields hold.
- R4: data_out equals the register at the port B address when the operand-B select is 0, and const_in when it is 1.
- R5: With the write enable at 1, the destination register takes the function-unit result when the write-back select is 0, and data_in when it is 1.
- R6: addr_out equals the register at the port A address, combinationally within the same cycle.
- R7: A read of the register being written in the same cycle returns its old value; the new value is readable from the next cycle on.
- R8: Arithmetic function codes (B = selected operand): 1 A+1, 2 A+B, 3 A+B+1, 4 A+~B, 5 A+~B+1, 6 A-1 (A plus all ones). C is the carry out of the W-bit add and V the signed overflow of that add.
- R9: Logic and shift codes: 0 pass A, 8 A AND B, 9 A OR B, 10 A XOR B, 11 NOT A, 12 pass B, 13 B shifted right by one with a zero fill, 14 B shifted left by one with a zero fill; codes 7 and 15 to 31 pass A. For all of these, C and V are 0.
- R10: N is the top bit of the function-unit result and Z is 1 exactly when that result is zero. Both follow the function unit even when the write-back select picks data_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_word | input | 17 | Control word applied this cycle |
| const_in | input | W | Constant offered as the second operand |
| data_in | input | W | External data offered for write-back |
| addr_out | output | W | Register file read port A value |
| data_out | output | W | Selected second operand |
| flag_v | output | 1 | Signed overflow of the function unit |
| flag_c | output | 1 | Carry out of the function unit |
| flag_n | output | 1 | Top bit of the function-unit result |
| flag_z | output | 1 | Function-unit result is zero |

## Verification
The hardest situations to reach from the ports are the flag corners, because overflow and carry only show for particular operand pairs that must first sit in registers, and the read-during-write case, where a control word must name the same register as destination and port A source. The stimulus first loads chosen corner values (0x00, 0x01, 0x7F, 0x80, 0xFF) through the data-in write-back path, then sweeps every function code over pairs of those registers and the constant, and issues self-targeted writes whose old value is checked on addr_out in the same cycle and whose new value is checked one cycle later. A long pseudo-random run with the behavioural model compared every cycle covers the rest.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int CW_W      = 17;
  localparam int REG_AW    = 3;
  localparam int NUM_REGS  = 1 << REG_AW;
  localparam int FS_W      = 5;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic              b_is_const;
    logic [FS_W-1:0]   func;
    logic              wb_is_ext;
    logic              wr_en;
  } ctrl_t;

  localparam logic [FS_W-1:0] FN_PASS_A  = 5'd0;
  localparam logic [FS_W-1:0] FN_INC     = 5'd1;
  localparam logic [FS_W-1:0] FN_ADD     = 5'd2;
  localparam logic [FS_W-1:0] FN_ADD_C   = 5'd3;
  localparam logic [FS_W-1:0] FN_ADD_NB  = 5'd4;
  localparam logic [FS_W-1:0] FN_SUB     = 5'd5;
  localparam logic [FS_W-1:0] FN_DEC     = 5'd6;
  localparam logic [FS_W-1:0] FN_AND     = 5'd8;
  localparam logic [FS_W-1:0] FN_OR      = 5'd9;
  localparam logic [FS_W-1:0] FN_XOR     = 5'd10;
  localparam logic [FS_W-1:0] FN_NOT_A   = 5'd11;
  localparam logic [FS_W-1:0] FN_PASS_B  = 5'd12;
  localparam logic [FS_W-1:0] FN_SHR_B   = 5'd13;
  localparam logic [FS_W-1:0] FN_SHL_B   = 5'd14;
endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W  = 8,
  parameter int AW = 3,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [N*W-1:0] regs_flat
);
  logic [W-1:0] q [N];
  logic [W-1:0] d [N];
  logic [N-1:0] en;

  for (genvar k = 0; k < N; k++) begin : g_reg
    always_comb begin
      en[k] = we && (wa == AW'(k));
      d[k]  = en[k] ? wd : q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[k] <= '0;
      else if (en[k]) q[k] <= d[k];
    end

    assign regs_flat[k*W +: W] = q[k];
  end

  assign rd_a = q[ra];
  assign rd_b = q[rb];
endmodule

// File: rtl/dp_func_unit.sv
module dp_func_unit
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FS_W-1:0] fs,
  output logic [W-1:0]    result,
  output logic            v,
  output logic            c,
  output logic            n,
  output logic            z
);
  logic [W-1:0] y;
  logic         cin;
  logic         use_add;
  logic [W:0]   sum_full;
  logic [W-1:0] logic_res;

  always_comb begin
    y       = '0;
    cin     = 1'b0;
    use_add = 1'b1;
    unique case (fs)
      FN_INC:    begin y = '0;  cin = 1'b1; end
      FN_ADD:    begin y = b;   cin = 1'b0; end
      FN_ADD_C:  begin y = b;   cin = 1'b1; end
      FN_ADD_NB: begin y = ~b;  cin = 1'b0; end
      FN_SUB:    begin y = ~b;  cin = 1'b1; end
      FN_DEC:    begin y = '1;  cin = 1'b0; end
      default:   use_add = 1'b0;
    endcase
  end

  assign sum_full = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};

  always_comb begin
    unique case (fs)
      FN_AND:    logic_res = a & b;
      FN_OR:     logic_res = a | b;
      FN_XOR:    logic_res = a ^ b;
      FN_NOT_A:  logic_res = ~a;
      FN_PASS_B: logic_res = b;
      FN_SHR_B:  logic_res = {1'b0, b[W-1:1]};
      FN_SHL_B:  logic_res = {b[W-2:0], 1'b0};
      default:   logic_res = a;
    endcase
  end

  assign result = use_add ? sum_full[W-1:0] : logic_res;
  assign c      = use_add & sum_full[W];
  assign v      = use_add & (a[W-1] == y[W-1]) & (sum_full[W-1] != a[W-1]);
  assign n      = result[W-1];
  assign z      = (result == '0);
endmodule

// File: rtl/ctrl_word_datapath.sv
module ctrl_word_datapath
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [W-1:0]    const_in,
  input  logic [W-1:0]    data_in,
  output logic [W-1:0]    addr_out,
  output logic [W-1:0]    data_out,
  output logic            flag_v,
  output logic            flag_c,
  output logic            flag_n,
  output logic            flag_z
);
  ctrl_t                 cw;
  logic                  rst_sync_n;
  logic [W-1:0]          port_a;
  logic [W-1:0]          port_b;
  logic [W-1:0]          opnd_b;
  logic [W-1:0]          fu_result;
  logic [W-1:0]          wb_data;
  logic [NUM_REGS*W-1:0] regs_flat;

  assign cw = ctrl_t'(ctrl_word);

  dp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dp_regfile #(.W(W), .AW(REG_AW)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (cw.wr_en),
    .wa        (cw.dst),
    .wd        (wb_data),
    .ra        (cw.src_a),
    .rb        (cw.src_b),
    .rd_a      (port_a),
    .rd_b      (port_b),
    .regs_flat (regs_flat)
  );

  assign opnd_b = cw.b_is_const ? const_in : port_b;

  dp_func_unit #(.W(W)) u_fu (
    .a      (port_a),
    .b      (opnd_b),
    .fs     (cw.func),
    .result (fu_result),
    .v      (flag_v),
    .c      (flag_c),
    .n      (flag_n),
    .z      (flag_z)
  );

  assign wb_data  = cw.wb_is_ext ? data_in : fu_result;
  assign addr_out = port_a;
  assign data_out = opnd_b;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [16:0]   ctrl_word,
  input logic [W-1:0]  const_in,
  input logic [W-1:0]  data_in,
  input logic [W-1:0]  addr_out,
  input logic [W-1:0]  data_out,
  input logic          flag_n,
  input logic          flag_z,
  input logic [8*W-1:0] regs_flat
);
  logic         ext_wr_q;
  logic [2:0]   ext_dst_q;
  logic [W-1:0] ext_val_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ext_wr_q  <= 1'b0;
      ext_dst_q <= '0;
      ext_val_q <= '0;
    end else begin
      ext_wr_q  <= ctrl_word[0] & ctrl_word[1];
      ext_dst_q <= ctrl_word[16:14];
      ext_val_q <= data_in;
    end
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_word[0] |=> $stable(regs_flat)); // R3

  AST_EXT_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_wr_q |-> regs_flat[ext_dst_q*W +: W] == ext_val_q); // R5

  AST_PORT_A_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_out == regs_flat[ctrl_word[13:11]*W +: W]); // R6

  AST_CONST_OPERAND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_word[7] |-> data_out == const_in); // R4

  AST_PASS_A_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_word[6:2] == 5'd0) |-> (flag_z == (addr_out == '0)) && (flag_n == addr_out[W-1])); // R10
endmodule

bind ctrl_word_datapath dp_checker #(.W(W)) u_dp_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ctrl_word  (ctrl_word),
  .const_in   (const_in),
  .data_in    (data_in),
  .addr_out   (addr_out),
  .data_out   (data_out),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .regs_flat  (regs_flat)
);

// File: tb/tb_ctrl_word_datapath.sv
`timescale 1ns/1ps
module tb_ctrl_word_datapath;
  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int MAX_CYCLES = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [16:0]  ctrl_word;
  logic [W-1:0] const_in;
  logic [W-1:0] data_in;
  logic [W-1:0] addr_out;
  logic [W-1:0] data_out;
  logic         flag_v, flag_c, flag_n, flag_z;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  int  model [8];

  always #2.5 clk = ~clk;

  ctrl_word_datapath #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  // R1: field layout of the control word, most significant field first
  function automatic logic [16:0] pack(int da, int aa, int ba, int mb, int fs, int md, int rw);
    return {3'(da), 3'(aa), 3'(ba), 1'(mb), 5'(fs), 1'(md), 1'(rw)};
  endfunction

  function automatic int sgn(int x);
    return (x >= (1 << (W-1))) ? x - (1 << W) : x;
  endfunction

  function automatic void fu_model(input int a, input int b, input int fs,
                                   output int r, output int c, output int v, output bit arith);
    int y, cin, full, s;
    arith = 1'b1; y = 0; cin = 0;
    case (fs)
      1: begin y = 0;           cin = 1; end
      2: begin y = b;           cin = 0; end
      3: begin y = b;           cin = 1; end
      4: begin y = ~b & MASK;   cin = 0; end
      5: begin y = ~b & MASK;   cin = 1; end
      6: begin y = MASK;        cin = 0; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      full = a + y + cin;
      r = full & MASK;
      c = full >> W;
      s = sgn(a) + sgn(y) + cin;
      v = (s > (1 << (W-1)) - 1 || s < -(1 << (W-1))) ? 1 : 0;
    end else begin
      c = 0; v = 0;
      case (fs)
        8:  r = a & b;
        9:  r = a | b;
        10: r = a ^ b;
        11: r = ~a & MASK;
        12: r = b;
        13: r = b >> 1;
        14: r = (b << 1) & MASK;
        default: r = a;
      endcase
    end
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one control word after a falling edge, compare outputs, then let the edge happen.
  task automatic step(int da, int aa, int ba, int mb, int fs, int md, int rw,
                      int k, int d, string tag);
    int a, b, r, c, v, wv;
    bit ar;
    @(negedge clk);
    ctrl_word = pack(da, aa, ba, mb, fs, md, rw);
    const_in  = W'(k);
    data_in   = W'(d);
    #1;
    a = model[aa];
    b = mb ? k : model[ba];
    fu_model(a, b, fs, r, c, v, ar);
    check(tag, "addr_out", int'(addr_out), a);
    check("R4", "data_out", int'(data_out), b);
    check(ar ? "R8" : "R9", "flag_c", int'(flag_c), c);
    check(ar ? "R8" : "R9", "flag_v", int'(flag_v), v);
    check("R10", "flag_n", int'(flag_n), (r >> (W-1)) & 1);
    check("R10", "flag_z", int'(flag_z), (r == 0) ? 1 : 0);
    wv = md ? d : r;
    @(posedge clk);
    if (rw) model[da] = wv;
  endtask

  initial begin
    #(MAX_CYCLES * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int vals [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    for (int i = 0; i < 8; i++) model[i] = 0;
    rst_n = 1'b0; ctrl_word = '0; const_in = '0; data_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2: every register reads zero after reset
    for (int i = 0; i < 8; i++) step(0, i, 7 - i, 0, 0, 0, 0, 0, 0, "R2");

    // R5 / R7: external write-back into every register, old value seen on the same cycle
    for (int i = 0; i < 8; i++) step(i, i, 0, 0, 0, 1, 1, 0, 8'h11 * (i + 1), "R7");
    for (int i = 0; i < 8; i++) step(0, i, i, 0, 0, 0, 0, 0, 0, "R5");

    // R5: function-unit write-back (R1 field placement: dst 5 from src 1 + src 2)
    step(5, 1, 2, 0, 2, 0, 1, 0, 8'hEE, "R5");
    step(0, 5, 0, 0, 0, 0, 0, 0, 0, "R5");

    // R3: writes disabled across many codes, then read all back
    for (int f = 0; f < 32; f++) step(f % 8, f % 8, 3, f % 2, f, f % 2, 0, 8'hA5, 8'h3C, "R3");
    for (int i = 0; i < 8; i++) step(0, i, 0, 0, 0, 0, 0, 0, 0, "R3");

    // R7: self-targeted write, new value only on the next cycle
    step(2, 2, 2, 0, 1, 0, 1, 0, 0, "R7");
    step(2, 2, 0, 0, 0, 1, 1, 0, 8'h5A, "R7");
    step(0, 2, 0, 0, 0, 0, 0, 0, 0, "R7");

    // R8 / R9: corner operands in registers 0..4, sweep every code
    for (int i = 0; i < 5; i++) step(i, 7, 0, 0, 0, 1, 1, 0, vals[i], "R6");
    for (int f = 0; f < 32; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          step(7, i, j, 0, f, 0, 1, 0, 0, "R6");
          step(6, i, 0, 1, f, 1, 1, vals[j], 8'h99, "R6");
        end

    // R6: pseudo-random traffic
    for (int t = 0; t < 3000; t++) begin
      int w = $urandom;
      step(w & 7, (w >> 3) & 7, (w >> 6) & 7, (w >> 9) & 1, (w >> 10) & 31,
           (w >> 15) & 1, (w >> 16) & 1, (w >> 17) & MASK, (w >> 24) & MASK, "R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule